// File: doc/BRIEF.md
# Continuous Trigger Pointer Generator

This block watches a stream of digitised samples as they are written into a circular sample memory. It never pauses, and it decides for each sample whether a trigger condition has just completed. Each trigger yields the memory address of the relevant sample, and that address is pushed into a small first-in first-out list of trigger pointers. Display or analysis logic later drains this list and uses each pointer to locate stored data. Nothing is disarmed while that logic is busy, so several triggers may land inside one screen width, and each one is kept.

Two detectors are built in. The edge detector fires when the signal crosses a level in the chosen direction, after it has first been armed on the far side of a hysteresis band. The runt detector reports pulses that rise past a low threshold and fall back below it without ever reaching a high threshold. For a runt, the pointer marks where the pulse first crossed the low threshold. When the list is full, further triggers are dropped and a sticky overflow flag is raised until it is cleared.

Top module: `trig_ptr_gen`

## Requirements
- R1: After synchronous reset, the list is empty, `fifo_valid` is 0, `fifo_count` is 0 and `ovf_flag` is 0.
- R2: In edge mode with `cfg_rising`=1, a valid sample with value+`cfg_hyst` < `cfg_level` arms the detector. An armed detector fires on the next valid sample with value >= `cfg_level`, pushes that sample's address and disarms.
- R3: In edge mode with `cfg_rising`=0, a valid sample with value > `cfg_level`+`cfg_hyst` arms the detector. An armed detector fires on a valid sample with value <= `cfg_level`, pushes its address and disarms.
- R4: Samples that stay within the hysteresis band after a trigger neither re-arm the edge detector nor fire it.
- R5: In runt mode, a pulse that reaches >= `cfg_low` and returns < `cfg_low` without reaching >= `cfg_high` pushes the address of its first sample >= `cfg_low`. The detector only accepts pulses after it has seen one sample < `cfg_low` since the last reset or configuration change.
- R6: In runt mode, a pulse that reaches `cfg_high` produces no trigger.
- R7: Detection has no dead time. Triggers on any samples, including triggers only two samples apart, are all recorded in order of occurrence.
- R8: The list is show-ahead. `fifo_addr` shows the oldest pointer while `fifo_valid`=1, and `fifo_pop` removes it. The list holds up to DEPTH pointers and reports the occupancy on `fifo_count`.
- R9: A trigger arriving when the list is full and no pop occurs in that cycle is dropped and sets `ovf_flag`. The flag stays set until `ovf_clear`, and a new drop in the same cycle as `ovf_clear` leaves it set. A trigger that arrives with a pop while the list is full is accepted.
- R10: In any cycle in which a configuration input differs from its value in the previous cycle, both detectors return to their initial state and that cycle's sample produces no trigger.
- R11: `cfg_mode` encodings are 2'b00 off, 2'b01 edge, 2'b10 runt and 2'b11 off. Samples with `smp_valid`=0 are ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | SW | Unsigned sample value |
| smp_addr | input | AW | Memory address the sample is written to |
| cfg_mode | input | 2 | Detector select |
| cfg_rising | input | 1 | Edge direction, 1 for rising |
| cfg_level | input | SW | Edge threshold |
| cfg_hyst | input | SW | Edge hysteresis band width |
| cfg_low | input | SW | Runt lower threshold |
| cfg_high | input | SW | Runt upper threshold |
| ovf_clear | input | 1 | Clears the overflow flag |
| fifo_pop | input | 1 | Removes the oldest pointer |
| fifo_valid | output | 1 | List holds at least one pointer |
| fifo_addr | output | AW | Oldest pointer |
| fifo_count | output | $clog2(DEPTH+1) | Number of stored pointers |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
Two pairs of events can coincide in one cycle. The first is a trigger arriving while the list is full. The second is an overflow drop arriving together with a software clear. The bench fills the list with a dense run of edge triggers. It then sends one trigger alongside `ovf_clear`, and the flag is expected to stay set. It sends another trigger alongside `fifo_pop`, and the count is expected to stay at DEPTH with the new pointer queued last. A behavioural queue model is compared against every output on every clock, and these outcomes are also checked directly against hand-derived addresses.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        MODE_OFF_A = 2'b00,
        MODE_EDGE  = 2'b01,
        MODE_RUNT  = 2'b10,
        MODE_OFF_B = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        RS_PRIME = 2'd0,
        RS_IDLE  = 2'd1,
        RS_LOW   = 2'd2,
        RS_HIGH  = 2'd3
    } runt_state_e;

    function automatic logic mode_is(input logic [1:0] raw, input trig_mode_e m);
        return trig_mode_e'(raw) == m;
    endfunction

endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic          valid,
    input  logic [SW-1:0] sample,
    input  logic          rising,
    input  logic [SW-1:0] level,
    input  logic [SW-1:0] hyst,
    output logic          fire
);
    localparam int XW = SW + 1;

    logic          armed;
    logic [XW-1:0] s_hyst;
    logic [XW-1:0] l_hyst;
    logic          arm_cond;
    logic          hit_cond;

    always_comb begin
        s_hyst   = XW'(sample) + XW'(hyst);
        l_hyst   = XW'(level) + XW'(hyst);
        arm_cond = rising ? (s_hyst < XW'(level)) : (XW'(sample) > l_hyst);
        hit_cond = rising ? (sample >= level) : (sample <= level);
        fire     = en && valid && !clr && armed && hit_cond;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed <= 1'b0;
        end else if (en && valid) begin
            if (fire)          armed <= 1'b0;
            else if (arm_cond) armed <= 1'b1;
        end
    end

endmodule

// File: rtl/trig_runt_det.sv
module trig_runt_det
    import trig_pkg::*;
#(
    parameter int SW = 8,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic          valid,
    input  logic [SW-1:0] sample,
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] lo,
    input  logic [SW-1:0] hi,
    output logic          fire,
    output logic [AW-1:0] fire_addr
);
    runt_state_e   st, st_nx;
    logic [AW-1:0] start_q;
    logic          take_start;

    always_comb begin
        st_nx      = st;
        take_start = 1'b0;
        fire       = 1'b0;
        unique case (st)
            RS_PRIME: if (sample < lo) st_nx = RS_IDLE;
            RS_IDLE: begin
                if (sample >= hi) begin
                    st_nx = RS_HIGH;
                end else if (sample >= lo) begin
                    st_nx      = RS_LOW;
                    take_start = 1'b1;
                end
            end
            RS_LOW: begin
                if (sample >= hi) begin
                    st_nx = RS_HIGH;
                end else if (sample < lo) begin
                    st_nx = RS_IDLE;
                    fire  = en && valid && !clr;
                end
            end
            RS_HIGH: if (sample < lo) st_nx = RS_IDLE;
            default: st_nx = RS_PRIME;
        endcase
        fire_addr = start_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st      <= RS_PRIME;
            start_q <= '0;
        end else if (en && valid) begin
            st <= st_nx;
            if (take_start) start_q <= addr;
        end
    end

endmodule

// File: rtl/trig_fifo.sv
module trig_fifo #(
    parameter int DW    = 10,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    input  logic                       pop,
    input  logic                       ovf_clr,
    output logic [DW-1:0]              head,
    output logic                       not_empty,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_p, rd_p;
    logic          pop_ok, push_ok, drop;

    always_comb begin
        pop_ok    = pop && (count != '0);
        push_ok   = push && ((count != CW'(DEPTH)) || pop_ok);
        drop      = push && !push_ok;
        head      = mem[rd_p];
        not_empty = (count != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_p  <= '0;
            rd_p  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push_ok) begin
                mem[wr_p] <= wdata;
                wr_p      <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
            end
            if (pop_ok) rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/trig_ptr_gen.sv
module trig_ptr_gen
    import trig_pkg::*;
#(
    parameter int SW    = 8,
    parameter int AW    = 10,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic [AW-1:0] smp_addr,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_rising,
    input  logic [SW-1:0] cfg_level,
    input  logic [SW-1:0] cfg_hyst,
    input  logic [SW-1:0] cfg_low,
    input  logic [SW-1:0] cfg_high,
    input  logic          ovf_clear,
    input  logic          fifo_pop,
    output logic          fifo_valid,
    output logic [AW-1:0] fifo_addr,
    output logic [CW-1:0] fifo_count,
    output logic          ovf_flag
);
    localparam int GW = 2 + 1 + 4 * SW;

    logic [GW-1:0] cfg_now, cfg_last;
    logic          cfg_chg;
    logic          edge_en, runt_en;
    logic          edge_fire, runt_fire;
    logic [AW-1:0] runt_addr;
    logic          ev;
    logic [AW-1:0] ev_addr;

    assign cfg_now = {cfg_mode, cfg_rising, cfg_level, cfg_hyst, cfg_low, cfg_high};
    assign cfg_chg = (cfg_now != cfg_last);
    assign edge_en = mode_is(cfg_mode, MODE_EDGE);
    assign runt_en = mode_is(cfg_mode, MODE_RUNT);

    always_ff @(posedge clk) begin
        cfg_last <= cfg_now;
    end

    trig_edge_det #(.SW(SW)) u_edge (
        .clk(clk), .rst(rst), .clr(cfg_chg), .en(edge_en), .valid(smp_valid),
        .sample(smp_data), .rising(cfg_rising), .level(cfg_level),
        .hyst(cfg_hyst), .fire(edge_fire)
    );

    trig_runt_det #(.SW(SW), .AW(AW)) u_runt (
        .clk(clk), .rst(rst), .clr(cfg_chg), .en(runt_en), .valid(smp_valid),
        .sample(smp_data), .addr(smp_addr), .lo(cfg_low), .hi(cfg_high),
        .fire(runt_fire), .fire_addr(runt_addr)
    );

    always_comb begin
        ev      = (edge_en && edge_fire) || (runt_en && runt_fire);
        ev_addr = runt_en ? runt_addr : smp_addr;
    end

    trig_fifo #(.DW(AW), .DEPTH(DEPTH)) u_list (
        .clk(clk), .rst(rst), .push(ev), .wdata(ev_addr), .pop(fifo_pop),
        .ovf_clr(ovf_clear), .head(fifo_addr), .not_empty(fifo_valid),
        .count(fifo_count), .ovf(ovf_flag)
    );

endmodule

// File: rtl/trig_ptr_gen_chk.sv
module trig_ptr_gen_chk #(
    parameter int AW    = 10,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cfg_mode,
    input logic          ovf_clear,
    input logic          fifo_pop,
    input logic          fifo_valid,
    input logic [AW-1:0] fifo_addr,
    input logic [CW-1:0] fifo_count,
    input logic          ovf_flag
);
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_count) <= DEPTH);

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_count) <= int'($past(fifo_count)) + 1);

    assert_head_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(fifo_valid) && !$past(fifo_pop)) |-> (fifo_valid && fifo_addr == $past(fifo_addr)));

    assert_ovf_needs_full_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (int'($past(fifo_count)) == DEPTH));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ovf_flag) && !$past(ovf_clear)) |-> ovf_flag);

    assert_off_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_mode) == 2'b00 || $past(cfg_mode) == 2'b11) |-> (fifo_count <= $past(fifo_count)));

endmodule

bind trig_ptr_gen trig_ptr_gen_chk #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .ovf_clear(ovf_clear),
    .fifo_pop(fifo_pop), .fifo_valid(fifo_valid), .fifo_addr(fifo_addr),
    .fifo_count(fifo_count), .ovf_flag(ovf_flag)
);

// File: tb/trig_ptr_gen_test.sv
`timescale 1ns/1ps
module trig_ptr_gen_test;
    localparam int SW = 8, AW = 10, DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 0, rst = 1;
    logic smp_valid = 0;
    logic [SW-1:0] smp_data = 0;
    logic [AW-1:0] smp_addr = 0;
    logic [1:0] cfg_mode = 0;
    logic cfg_rising = 1;
    logic [SW-1:0] cfg_level = 0, cfg_hyst = 0, cfg_low = 0, cfg_high = 0;
    logic ovf_clear = 0, fifo_pop = 0;
    logic fifo_valid;
    logic [AW-1:0] fifo_addr;
    logic [CW-1:0] fifo_count;
    logic ovf_flag;

    int checks = 0, fails = 0;
    bit finished = 0;

    trig_ptr_gen #(.SW(SW), .AW(AW), .DEPTH(DEPTH)) uut (.*);

    always #10 clk = ~clk;

    // behavioural reference
    int q[$];
    int m_ovf = 0, m_armed = 0, m_rs = 0, m_start = 0;
    logic [GWB-1:0] m_prev;
    localparam int GWB = 3 + 4 * SW;
    wire [GWB-1:0] cfg_bus = {cfg_mode, cfg_rising, cfg_level, cfg_hyst, cfg_low, cfg_high};

    always @(posedge clk) begin
        int s, ev, ea;
        bit popok, acc;
        if (rst) begin
            q.delete(); m_ovf = 0; m_armed = 0; m_rs = 0; m_start = 0;
        end else begin
            s = smp_data; ev = 0; ea = 0;
            if (cfg_bus != m_prev) begin
                m_armed = 0; m_rs = 0;
            end else if (smp_valid) begin
                if (cfg_mode == 2'b01) begin
                    if (cfg_rising) begin
                        if (m_armed && s >= cfg_level) begin ev = 1; ea = smp_addr; m_armed = 0; end
                        else if (s + cfg_hyst < cfg_level) m_armed = 1;
                    end else begin
                        if (m_armed && s <= cfg_level) begin ev = 1; ea = smp_addr; m_armed = 0; end
                        else if (s > cfg_level + cfg_hyst) m_armed = 1;
                    end
                end else if (cfg_mode == 2'b10) begin
                    case (m_rs)
                        0: if (s < cfg_low) m_rs = 1;
                        1: if (s >= cfg_high) m_rs = 3;
                           else if (s >= cfg_low) begin m_rs = 2; m_start = smp_addr; end
                        2: if (s >= cfg_high) m_rs = 3;
                           else if (s < cfg_low) begin m_rs = 1; ev = 1; ea = m_start; end
                        default: if (s < cfg_low) m_rs = 1;
                    endcase
                end
            end
            popok = fifo_pop && q.size() > 0;
            acc = ev && (q.size() < DEPTH || popok);
            if (popok) void'(q.pop_front());
            if (acc) q.push_back(ea);
            if (ev && !acc) m_ovf = 1;
            else if (ovf_clear) m_ovf = 0;
        end
        m_prev = cfg_bus;
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R8 model valid", fifo_valid, q.size() > 0);
            check("R8 model count", fifo_count, q.size());
            check("R9 model overflow", ovf_flag, m_ovf);
            if (q.size() > 0) check("R7 model head", fifo_addr, q[0]);
        end
    end

    task automatic set_cfg(int mode, int rising, int level, int hyst, int lo, int hi);
        @(negedge clk); #1;
        smp_valid = 0; fifo_pop = 0; ovf_clear = 0;
        cfg_mode = mode[1:0]; cfg_rising = rising[0];
        cfg_level = level[SW-1:0]; cfg_hyst = hyst[SW-1:0];
        cfg_low = lo[SW-1:0]; cfg_high = hi[SW-1:0];
    endtask

    task automatic send(int v, int a);
        @(negedge clk); #1;
        smp_valid = 1; smp_data = v[SW-1:0]; smp_addr = a[AW-1:0];
        fifo_pop = 0; ovf_clear = 0;
    endtask

    task automatic idle();
        @(negedge clk); #1;
        smp_valid = 0; fifo_pop = 0; ovf_clear = 0;
    endtask

    task automatic expect_pop(string tag, int a);
        @(negedge clk); #1;
        smp_valid = 0; ovf_clear = 0;
        check({tag, " head present"}, fifo_valid, 1);
        check({tag, " head addr"}, fifo_addr, a);
        fifo_pop = 1;
        @(negedge clk); #1;
        fifo_pop = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset valid", fifo_valid, 0);
        check("R1 reset count", fifo_count, 0);
        check("R1 reset overflow", ovf_flag, 0);
        rst = 0;

        // rising edge with hysteresis
        set_cfg(1, 1, 100, 10, 0, 0);
        idle();
        send(50, 1); send(120, 2); send(95, 3); send(105, 4); send(80, 5); send(130, 6);
        idle();
        check("R4 count after band", fifo_count, 2);
        expect_pop("R2", 2);
        expect_pop("R4", 6);

        // falling edge
        set_cfg(1, 0, 100, 10, 0, 0);
        idle();
        send(200, 10); send(90, 11);
        idle();
        expect_pop("R3", 11);

        // config change clears arming
        send(200, 20);
        @(negedge clk); #1;
        cfg_level = 101; smp_valid = 1; smp_data = 90; smp_addr = 21;
        send(90, 22);
        idle();
        check("R10 no trigger across change", fifo_count, 0);

        // runt
        set_cfg(2, 1, 0, 0, 50, 150);
        idle();
        send(10, 30); send(80, 31); send(90, 32); send(20, 33);
        send(60, 34); send(160, 35); send(20, 36);
        send(70, 37); send(10, 38);
        set_cfg(2, 1, 0, 0, 50, 151);
        send(80, 41); send(10, 42);
        idle();
        check("R6 full pulse ignored", fifo_count, 2);
        expect_pop("R5", 31);
        expect_pop("R5", 37);

        // dense triggers and overflow
        set_cfg(1, 1, 100, 0, 0, 0);
        idle();
        for (int k = 0; k < 12; k++) begin
            send(50, 100 + 2 * k);
            send(150, 101 + 2 * k);
        end
        idle();
        check("R9 full count", fifo_count, DEPTH);
        check("R9 overflow set", ovf_flag, 1);
        @(negedge clk); #1; ovf_clear = 1;
        @(negedge clk); #1; ovf_clear = 0;
        check("R9 overflow cleared", ovf_flag, 0);
        send(50, 130);
        @(negedge clk); #1;
        smp_valid = 1; smp_data = 150; smp_addr = 131; ovf_clear = 1;
        idle();
        check("R9 set wins over clear", ovf_flag, 1);
        send(50, 132);
        @(negedge clk); #1;
        smp_valid = 1; smp_data = 150; smp_addr = 133; fifo_pop = 1;
        idle();
        check("R9 push with pop at full", fifo_count, DEPTH);
        for (int k = 1; k < DEPTH; k++) expect_pop("R7", 101 + 2 * k);
        expect_pop("R9", 133);

        // disabled modes and invalid samples
        set_cfg(3, 1, 100, 0, 0, 0);
        send(50, 200); send(150, 201);
        set_cfg(0, 1, 100, 0, 0, 0);
        send(50, 202); send(150, 203);
        idle();
        check("R11 off modes quiet", fifo_count, 0);
        set_cfg(1, 1, 100, 0, 0, 0);
        idle();
        send(50, 210);
        @(negedge clk); #1;
        smp_valid = 0; smp_data = 150; smp_addr = 211;
        idle();
        check("R11 invalid sample ignored", fifo_count, 0);
        send(150, 212);
        idle();
        expect_pop("R11", 212);
        idle();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule